// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit bidirectional buses, called A and B, and moves data in either direction. Each direction owns one storage register, its own capture strobe, its own select that chooses between the live value of the source bus and the stored value, and its own output enable. The enable for the B side is active high and the enable for the A side is active low. Tri-state pins are split into an input value, an output value and an output enable per bus, so the surrounding logic (or a bench) resolves the physical bus.

The design runs on one fast sampling clock. The per-direction capture strobes `clk_ab` and `clk_ba` are treated as synchronous levels: a register loads on the first sampling edge at which its strobe is seen high after having been low. Live transfer is purely combinational from the source bus to the driven bus, so a change on the source is seen on the far side without waiting for any edge. Because a driven bus is also read back as an input, a capture in the other direction can store the value this block is itself driving, which lets one source fill both registers. A `test_mode` input takes both buses out of normal function so that an external boundary-scan block can own the pins.

Top module: `bus_xcvr`

## Requirements
- R1: While `rst` is high at a rising `clk` edge both registers clear to 8'h00; the first stored values seen after reset are zero on both buses.
- R2: The A-to-B register loads `a_in` on the first rising `clk` edge at which `clk_ab` is 1 after being 0 at the previous edge; the new value is visible right after that edge.
- R3: The B-to-A register loads `b_in` on the first rising `clk` edge at which `clk_ba` is 1 after being 0 at the previous edge.
- R4: With `sel_ab` = 0, `b_out` equals `a_in` combinationally; with `sel_ab` = 1, `b_out` equals the A-to-B register.
- R5: With `sel_ba` = 0, `a_out` equals `b_in` combinationally; with `sel_ba` = 1, `a_out` equals the B-to-A register.
- R6: `b_oe` is 1 exactly when `oe_ab` = 1 and `a_oe` is 1 exactly when `oe_ba_n` = 0 (both with `test_mode` = 0), independent of `rst` and of the registers.
- R7: Captures happen whatever the enables are: with `oe_ab` = 0 and `oe_ba_n` = 1 neither bus is driven and both registers still load from the external drivers.
- R8: With `oe_ab` = 1, `oe_ba_n` = 1 and `sel_ab` = 0, a `clk_ba` capture stores the A value driven onto B, so both registers hold A data; the mirror case with both enables low and `sel_ba` = 0 fills both registers with B data.
- R9: With both buses driven from stored data (`oe_ab` = 1, `oe_ba_n` = 0, both selects 1), both registers appear at once on the opposite buses, and captures on both strobes at the same edge take the pre-edge bus values, so the two registers exchange contents.
- R10: While `test_mode` = 1 both `a_oe` and `b_oe` are 0 and strobe edges load nothing; register contents are unchanged after `test_mode` returns to 0.
- R11: A strobe held high for many edges loads once; later changes on the source bus are not stored until the strobe goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of both registers |
| test_mode | input | 1 | Inhibits driving and capture for an external scan owner |
| clk_ab | input | 1 | Capture strobe of the A-to-B register (rising level change) |
| clk_ba | input | 1 | Capture strobe of the B-to-A register (rising level change) |
| sel_ab | input | 1 | B-side source: 0 live A bus, 1 stored A-to-B data |
| sel_ba | input | 1 | A-side source: 0 live B bus, 1 stored B-to-A data |
| oe_ab | input | 1 | Active-high enable of the B-side drivers |
| oe_ba_n | input | 1 | Active-low enable of the A-side drivers |
| a_in | input | 8 | Resolved value of the A bus |
| a_out | output | 8 | Value this block offers to the A bus |
| a_oe | output | 1 | Drives `a_out` onto the A bus when 1 |
| b_in | input | 8 | Resolved value of the B bus |
| b_out | output | 8 | Value this block offers to the B bus |
| b_oe | output | 1 | Drives `b_out` onto the B bus when 1 |

## Verification
The functions that meet in one cycle are a capture in one direction and this block driving the bus that capture reads: the bench holds one direction enabled while pulsing the opposite strobe, and also pulses both strobes at the same sampling edge while both buses are driven from stored data. The scoreboard judges the outcome by turning the paths to stored mode afterwards and reading each register through the bus it drives, expecting either the copied source value or the exchanged pair. A contention monitor resolves each bus from the bench driver and the block's enable and flags any cycle in which both drive it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int DATA_W = 8;

  typedef enum logic {
    PICK_LIVE = 1'b0,
    PICK_HELD = 1'b1
  } pick_t;

endpackage

// File: rtl/xcvr_edge_strobe.sv
module xcvr_edge_strobe (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic block,
  output logic strobe
);

  logic last_q;

  // Held at 1 through reset so a strobe already high is not taken as an edge.
  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= level;
  end

  assign strobe = level & ~last_q & ~block & ~rst;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W         = xcvr_pkg::DATA_W,
  parameter bit INVERT_OE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] src,
  input  logic         sel,
  input  logic         oe_pin,
  input  logic         inhibit,
  output logic [W-1:0] held,
  output logic [W-1:0] drv,
  output logic         drv_en
);

  import xcvr_pkg::*;

  pick_t pick;
  logic  en_raw;

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= src;
  end

  assign pick = pick_t'(sel);
  assign drv  = (pick == PICK_HELD) ? held : src;

  generate
    if (INVERT_OE) begin : g_low_en
      assign en_raw = ~oe_pin;
    end else begin : g_high_en
      assign en_raw = oe_pin;
    end
  endgenerate

  assign drv_en = en_raw & ~inhibit;

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic         load_ab;
  logic         load_ba;
  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  xcvr_edge_strobe u_edge_ab (
    .clk    (clk),
    .rst    (rst),
    .level  (clk_ab),
    .block  (test_mode),
    .strobe (load_ab)
  );

  xcvr_edge_strobe u_edge_ba (
    .clk    (clk),
    .rst    (rst),
    .level  (clk_ba),
    .block  (test_mode),
    .strobe (load_ba)
  );

  // A bus feeds the B side; enable active high.
  xcvr_lane #(.W(W), .INVERT_OE(1'b0)) u_lane_ab (
    .clk     (clk),
    .rst     (rst),
    .load    (load_ab),
    .src     (a_in),
    .sel     (sel_ab),
    .oe_pin  (oe_ab),
    .inhibit (test_mode),
    .held    (held_ab),
    .drv     (b_out),
    .drv_en  (b_oe)
  );

  // B bus feeds the A side; enable active low.
  xcvr_lane #(.W(W), .INVERT_OE(1'b1)) u_lane_ba (
    .clk     (clk),
    .rst     (rst),
    .load    (load_ba),
    .src     (b_in),
    .sel     (sel_ba),
    .oe_pin  (oe_ba_n),
    .inhibit (test_mode),
    .held    (held_ba),
    .drv     (a_out),
    .drv_en  (a_oe)
  );

endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input logic         clk,
  input logic         rst,
  input logic         test_mode,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] held_ab,
  input logic [W-1:0] held_ba
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (held_ab == '0) && (held_ba == '0)); // R1

  AST_LOAD_AB: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_ab) && !test_mode && !$past(rst)) |=> held_ab == $past(a_in)); // R2

  AST_LOAD_BA: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_ba) && !test_mode && !$past(rst)) |=> held_ba == $past(b_in)); // R3

  AST_PICK_AB_HELD: assert property (@(posedge clk) disable iff (rst)
    sel_ab |-> b_out == held_ab); // R4

  AST_PICK_AB_LIVE: assert property (@(posedge clk) disable iff (rst)
    !sel_ab |-> b_out == a_in); // R4

  AST_PICK_BA_HELD: assert property (@(posedge clk) disable iff (rst)
    sel_ba |-> a_out == held_ba); // R5

  AST_PICK_BA_LIVE: assert property (@(posedge clk) disable iff (rst)
    !sel_ba |-> a_out == b_in); // R5

  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> !a_oe && !b_oe); // R10

  AST_TEST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> $stable(held_ab) && $stable(held_ba)); // R10

  AST_HOLD_AB: assert property (@(posedge clk) disable iff (rst)
    !$rose(clk_ab) |=> $stable(held_ab)); // R11

  AST_HOLD_BA: assert property (@(posedge clk) disable iff (rst)
    !$rose(clk_ba) |=> $stable(held_ba)); // R11

endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .test_mode (test_mode),
  .clk_ab    (clk_ab),
  .clk_ba    (clk_ba),
  .sel_ab    (sel_ab),
  .sel_ba    (sel_ba),
  .a_in      (a_in),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_in      (b_in),
  .b_out     (b_out),
  .b_oe      (b_oe),
  .held_ab   (held_ab),
  .held_ba   (held_ba)
);

// File: tb/bus_xcvr_bench.sv
`timescale 1ns/1ps
module bus_xcvr_bench;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_mode = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0;
  logic sel_ab = 1'b1, sel_ba = 1'b1;
  logic oe_ab = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] a_ext = '0, b_ext = '0;
  logic a_ext_en = 1'b0, b_ext_en = 1'b0;
  wire  [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // Bus resolution with a short wire delay; undriven bus reads as zero.
  assign #0.2 a_in = a_oe ? a_out : (a_ext_en ? a_ext : '0);
  assign #0.2 b_in = b_oe ? b_out : (b_ext_en ? b_ext : '0);

  bus_xcvr #(.W(W)) u_bus_xcvr (
    .clk(clk), .rst(rst), .test_mode(test_mode),
    .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct {
    string        req;
    logic         eao;
    logic [W-1:0] ea;
    logic         ebo;
    logic [W-1:0] eb;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;

  // Scoreboard monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (a_oe !== it.eao || b_oe !== it.ebo ||
            (it.eao && a_out !== it.ea) || (it.ebo && b_out !== it.eb)) begin
          errors++;
          $display("FAIL %s: a_oe=%b a_out=%h b_oe=%b b_out=%h, expected a_oe=%b a_out=%h b_oe=%b b_out=%h",
                   it.req, a_oe, a_out, b_oe, b_out, it.eao, it.ea, it.ebo, it.eb);
        end
      end
    end
  end

  // Contention monitor, mid-cycle.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && ((a_ext_en && a_oe) || (b_ext_en && b_oe))) begin
        errors++;
        $display("FAIL R6 contention: a_ext_en=%b a_oe=%b b_ext_en=%b b_oe=%b, expected no shared driver",
                 a_ext_en, a_oe, b_ext_en, b_oe);
      end
    end
  end

  // Watchdog.
  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic expect_bus(input string req, input logic eao, input logic [W-1:0] ea,
                            input logic ebo, input logic [W-1:0] eb);
    item_t it;
    #1;
    it.req = req; it.eao = eao; it.ea = ea; it.ebo = ebo; it.eb = eb;
    sb_q.push_back(it);
    -> mon_ev;
    #0.1;
  endtask

  task automatic ctl(input logic oab, input logic obn, input logic sab, input logic sba);
    @(negedge clk);
    oe_ab = oab; oe_ba_n = obn; sel_ab = sab; sel_ba = sba;
  endtask

  task automatic ext(input logic ae, input logic [W-1:0] av, input logic be, input logic [W-1:0] bv);
    a_ext_en = ae; a_ext = av; b_ext_en = be; b_ext = bv;
  endtask

  task automatic pulse(input logic ab, input logic ba);
    @(negedge clk);
    clk_ab = ab; clk_ba = ba;
    @(negedge clk);
    clk_ab = 1'b0; clk_ba = 1'b0;
  endtask

  // Read both registers through stored mode with both sides driving.
  task automatic reveal(input string req, input logic [W-1:0] hab, input logic [W-1:0] hba);
    @(negedge clk);
    ext(1'b0, '0, 1'b0, '0);
    oe_ab = 1'b1; oe_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    expect_bus(req, 1'b1, hba, 1'b1, hab);
  endtask

  initial begin
    // R1, R6: enables follow pins during reset, registers cleared.
    oe_ab = 1'b1; oe_ba_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_bus("R6 enables during reset", 1'b1, 8'h00, 1'b1, 8'h00);
    rst = 1'b0;
    expect_bus("R1 cleared after reset", 1'b1, 8'h00, 1'b1, 8'h00);

    // R7: isolation, both registers load from external drivers.
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    ext(1'b1, 8'h3C, 1'b1, 8'hA5);
    expect_bus("R7 isolation no drive", 1'b0, 8'h00, 1'b0, 8'h00);
    pulse(1'b1, 1'b1);
    expect_bus("R7 isolation still quiet", 1'b0, 8'h00, 1'b0, 8'h00);
    reveal("R2 R3 R7 stored after isolation", 8'h3C, 8'hA5);

    // R4: live A to B follows without a strobe.
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    ext(1'b1, 8'h5A, 1'b0, '0);
    expect_bus("R4 live A to B", 1'b0, 8'h00, 1'b1, 8'h5A);
    @(negedge clk); a_ext = 8'h0F;
    expect_bus("R4 live A follows change", 1'b0, 8'h00, 1'b1, 8'h0F);
    ctl(1'b1, 1'b1, 1'b1, 1'b1);
    expect_bus("R4 stored A to B", 1'b0, 8'h00, 1'b1, 8'h3C);

    // R5: live B to A, then stored.
    ctl(1'b0, 1'b0, 1'b1, 1'b0);
    ext(1'b0, '0, 1'b1, 8'h99);
    expect_bus("R5 live B to A", 1'b1, 8'h99, 1'b0, 8'h00);
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    expect_bus("R5 stored B to A", 1'b1, 8'hA5, 1'b0, 8'h00);

    // R8: A drives B, both strobes together, A data in both registers.
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    ext(1'b1, 8'h77, 1'b0, '0);
    pulse(1'b1, 1'b1);
    reveal("R8 A data in both registers", 8'h77, 8'h77);

    // R8 mirror: B drives A, B data in both registers.
    ctl(1'b0, 1'b0, 1'b1, 1'b0);
    ext(1'b0, '0, 1'b1, 8'h42);
    pulse(1'b1, 1'b1);
    reveal("R8 B data in both registers", 8'h42, 8'h42);

    // R9: distinct stored values on both buses, then a coincident swap.
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    ext(1'b1, 8'h11, 1'b1, 8'h22);
    pulse(1'b1, 1'b1);
    reveal("R9 both stored outputs at once", 8'h11, 8'h22);
    pulse(1'b1, 1'b1);
    expect_bus("R9 coincident captures exchange", 1'b1, 8'h11, 1'b1, 8'h22);

    // R10: test mode silences drivers and ignores strobes.
    @(negedge clk);
    test_mode = 1'b1;
    expect_bus("R10 drivers off in test mode", 1'b0, 8'h00, 1'b0, 8'h00);
    ext(1'b1, 8'hEE, 1'b1, 8'hDD);
    pulse(1'b1, 1'b1);
    expect_bus("R10 still off after strobes", 1'b0, 8'h00, 1'b0, 8'h00);
    @(negedge clk);
    ext(1'b0, '0, 1'b0, '0);
    test_mode = 1'b0;
    reveal("R10 registers unchanged", 8'h22, 8'h11);

    // R11: strobe held high loads only once.
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    ext(1'b1, 8'h81, 1'b0, '0);
    @(negedge clk); clk_ab = 1'b1;
    @(negedge clk); a_ext = 8'h18;
    repeat (3) @(negedge clk);
    a_ext_en = 1'b0;
    oe_ab = 1'b1;
    expect_bus("R11 held strobe loads once", 1'b0, 8'h00, 1'b1, 8'h81);
    @(negedge clk); clk_ab = 1'b0;
    a_ext_en = 1'b1; oe_ab = 1'b0;
    pulse(1'b1, 1'b0);
    @(negedge clk); a_ext_en = 1'b0; oe_ab = 1'b1;
    expect_bus("R2 new edge loads again", 1'b0, 8'h00, 1'b1, 8'h18);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule